// File: doc/BRIEF.md
# Pin Edge Interrupt Flag Unit

This block watches two 8-bit groups of input pins and reports pin transitions to an interrupt controller. Every pin has its own programmable polarity bit, which picks a rising or a falling transition, and its own enable bit. Every pin also has a sticky flag. The flag latches when the chosen transition appears on the pin and stays set until software clears it. Each group combines its enabled flags into one level-type request line. There is one request line per group.

Software reaches the unit through a byte-wide register bus. Each group has a 16-byte window. Within that window there are four live registers: the synchronised pin levels, the enable bits, the polarity bits and the flags. Writes take effect on the clock edge at which `bus_wen` is sampled high. Reads are combinational. The bus has no handshake: it accepts a write on every cycle and never applies back-pressure, so no valid/ready pair is needed. External pins are asynchronous. They are re-timed inside the block before any transition is judged.

Top module: `gpio_edge_irq`

## Requirements
- R1: With polarity bit 0, a low-to-high change on a pin sets that pin's flag. The flag reads 1 three clock edges after the pin changes.
- R2: With polarity bit 1, a high-to-low change on a pin sets that pin's flag, with the same three-edge latency.
- R3: A transition in the direction that was not selected leaves the flag at 0.
- R4: Writing 1 to a flag bit (offset 0x7) clears it at the next clock edge. Writing 0 leaves it as it was. No other event clears a flag.
- R5: If a transition that would set a flag arrives on the same edge as a write of 1 to that flag, the flag ends up set.
- R6: A flag records transitions whatever its enable bit is. A group's request line is high exactly when at least one of its flags and the matching enable bit (offset 0x5) are both 1. The line changes on the same edge as the flag or the enable.
- R7: Group 0 occupies addresses 0x00 to 0x0F and group 1 occupies 0x10 to 0x1F. Each group's pins, registers and request line are independent of the other group.
- R8: Offset 0x0 returns the group's pin levels. A change appears there two clock edges after it arrives on the pins.
- R9: After reset, the enable, polarity and flag registers are all 0 and both request lines are low.
- R10: The enable (offset 0x5) and polarity (offset 0x6) registers read back what was written. Every other offset in a window reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Asynchronous pins. Bits 7:0 are group 0 and bits 15:8 are group 1 |
| bus_addr | input | 5 | Register address. Bit 4 selects the group and bits 3:0 the offset |
| bus_wen | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_o | output | 2 | Level request per group, bit 0 for group 0 |

## Verification
A pin change is due on the flags and the request lines three rising edges after it is driven: two re-timing stages plus the previous-value stage. The pin-level register shows the change after two edges. Writes to enables, polarities and flags show after one edge, and reads answer within the same cycle. The bench drives every input just after a falling edge. It checks the request lines at the next falling edge, before it drives anything new. It checks read data 1 ns after driving the address. Its model advances its own three-stage pin history once per cycle, so every expected value falls into the cycle in which it is due.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int OFS_W = 4;
  localparam logic [OFS_W-1:0] OFS_LEVEL = 4'h0;
  localparam logic [OFS_W-1:0] OFS_ENAB  = 4'h5;
  localparam logic [OFS_W-1:0] OFS_POL   = 4'h6;
  localparam logic [OFS_W-1:0] OFS_FLAG  = 4'h7;

  typedef enum logic {
    POL_RISE = 1'b0,
    POL_FALL = 1'b1
  } pol_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] pol_fall,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  // rising where polarity selects rise, falling where it selects fall
  assign hit = (cur & ~prev_q & ~pol_fall) | (~cur & prev_q & pol_fall);
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] edge_hit,
  input  logic         wr_enab,
  input  logic         wr_pol,
  input  logic         wr_flag,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] enab_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] flag_q,
  output logic         irq
);
  logic [W-1:0] clr_mask;

  assign clr_mask = wr_flag ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enab_q <= '0;
      pol_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_enab) enab_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      flag_q <= (flag_q & ~clr_mask) | edge_hit;
    end
  end

  assign irq = |(flag_q & enab_q);

  // R1 R2: a flag bit only rises on a detected transition
  p_rise_needs_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) & ~$past(edge_hit)) == '0);

  // R4: without a flag write no bit drops
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R4: written ones clear when no transition competes
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && ((wdata & edge_hit) == '0)) |=> ((flag_q & $past(wdata)) == '0));

  // R5: a transition always leaves its flag set, even against a clear
  p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  // R6: no enable, no request
  p_no_enab_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enab_q == '0) |-> !irq);
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS   = 2,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PSEL_W     = $clog2(NUM_PORTS),
  localparam int ADDR_W     = OFS_W + PSEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_i,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wen,
  input  logic [PORT_W-1:0]           bus_wdata,
  output logic [PORT_W-1:0]           bus_rdata,
  output logic [NUM_PORTS-1:0]        irq_o
);
  logic [PSEL_W-1:0] port_sel;
  logic [OFS_W-1:0]  offset;

  logic [PORT_W-1:0] level_w [NUM_PORTS];
  logic [PORT_W-1:0] enab_w  [NUM_PORTS];
  logic [PORT_W-1:0] pol_w   [NUM_PORTS];
  logic [PORT_W-1:0] flag_w  [NUM_PORTS];

  assign port_sel = bus_addr[ADDR_W-1:OFS_W];
  assign offset   = bus_addr[OFS_W-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] hit_w;
    logic              sel_w;

    assign sel_w = bus_wen && (int'(port_sel) == p);

    gpio_pin_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_i[p*PORT_W +: PORT_W]),
      .q     (level_w[p])
    );

    gpio_edge_det #(.W(PORT_W)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur      (level_w[p]),
      .pol_fall (pol_w[p]),
      .hit      (hit_w)
    );

    gpio_port_irq #(.W(PORT_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .edge_hit (hit_w),
      .wr_enab  (sel_w && (offset == OFS_ENAB)),
      .wr_pol   (sel_w && (offset == OFS_POL)),
      .wr_flag  (sel_w && (offset == OFS_FLAG)),
      .wdata    (bus_wdata),
      .enab_q   (enab_w[p]),
      .pol_q    (pol_w[p]),
      .flag_q   (flag_w[p]),
      .irq      (irq_o[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(port_sel) < NUM_PORTS) begin
      case (offset)
        OFS_LEVEL: bus_rdata = level_w[port_sel];
        OFS_ENAB:  bus_rdata = enab_w[port_sel];
        OFS_POL:   bus_rdata = pol_w[port_sel];
        OFS_FLAG:  bus_rdata = flag_w[port_sel];
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R9: request lines stay low in the first cycle out of reset
  p_irq_low_after_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0));
endmodule

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic [4:0]  addr = '0;
  logic        wen = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_s1 = '0, m_s2 = '0, m_pv = '0;
  logic [15:0] m_flag = '0, m_enab = '0, m_pol = '0;

  gpio_edge_irq u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_addr(addr),
    .bus_wen(wen), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    int p = int'(a[4]);
    case (a[3:0])
      4'h0: return m_s2[p*8 +: 8];
      4'h5: return m_enab[p*8 +: 8];
      4'h6: return m_pol[p*8 +: 8];
      4'h7: return m_flag[p*8 +: 8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] exp_irq();
    return {|(m_flag[15:8] & m_enab[15:8]), |(m_flag[7:0] & m_enab[7:0])};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] p, input logic we, input logic [4:0] a,
                      input logic [7:0] d, input string tag);
    logic [15:0] set, clr;
    @(negedge clk);
    check(tag, "irq", {14'd0, irq}, {14'd0, exp_irq()});
    pins = p; addr = a; wen = we; wdata = d;
    #1;
    if (!we) check(tag, $sformatf("read %h", a), {8'd0, rdata}, {8'd0, exp_rd(a)});
    set = (m_s2 & ~m_pv & ~m_pol) | (~m_s2 & m_pv & m_pol);
    clr = '0;
    if (we) begin
      case (a[3:0])
        4'h5: m_enab[a[4]*8 +: 8] = d;
        4'h6: m_pol[a[4]*8 +: 8]  = d;
        4'h7: clr[a[4]*8 +: 8]    = d;
        default: ;
      endcase
    end
    m_flag = (m_flag & ~clr) | set;
    m_pv = m_s2; m_s2 = m_s1; m_s1 = p;
  endtask

  task automatic idle(input int n, input logic [4:0] a, input string tag);
    for (int i = 0; i < n; i++) step(pins, 1'b0, a, 8'h00, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    step(pins, 0, 5'h05, 0, "R9"); step(pins, 0, 5'h06, 0, "R9");
    step(pins, 0, 5'h07, 0, "R9"); step(pins, 0, 5'h15, 0, "R9");
    step(pins, 0, 5'h16, 0, "R9"); step(pins, 0, 5'h17, 0, "R9");
    // R10 readback and unmapped offsets
    step(pins, 1, 5'h05, 8'hA5, "R10"); step(pins, 0, 5'h05, 0, "R10");
    step(pins, 1, 5'h16, 8'h3C, "R10"); step(pins, 0, 5'h16, 0, "R10");
    step(pins, 0, 5'h03, 0, "R10"); step(pins, 0, 5'h1A, 0, "R10");
    step(pins, 1, 5'h05, 8'h00, "R10"); step(pins, 1, 5'h16, 8'h00, "R10");
    // R1 rising on bit 0: flag readable on the fourth read
    step(16'h0001, 0, 5'h07, 0, "R1"); idle(3, 5'h07, "R1");
    check("R1", "flag bit0", {8'd0, rdata}, 16'h0001);
    // R4 write 0 keeps, write 1 clears
    step(pins, 1, 5'h07, 8'h00, "R4"); step(pins, 0, 5'h07, 0, "R4");
    step(pins, 1, 5'h07, 8'h01, "R4"); step(pins, 0, 5'h07, 0, "R4");
    check("R4", "flag cleared", {8'd0, rdata}, 16'h0000);
    // R3 rising on bit 1 with falling selected
    step(pins, 1, 5'h06, 8'h02, "R3");
    step(16'h0003, 0, 5'h07, 0, "R3"); idle(4, 5'h07, "R3");
    check("R3", "no flag", {8'd0, rdata}, 16'h0000);
    // R2 falling on bit 1
    step(16'h0001, 0, 5'h07, 0, "R2"); idle(3, 5'h07, "R2");
    check("R2", "flag bit1", {8'd0, rdata}, 16'h0002);
    // R6 flag without enable gives no request, then enable raises it
    step(pins, 0, 5'h07, 0, "R6");
    step(pins, 1, 5'h05, 8'h02, "R6"); step(pins, 0, 5'h07, 0, "R6");
    check("R6", "irq group0", {14'd0, irq}, 16'h0001);
    step(pins, 1, 5'h07, 8'h02, "R6"); idle(2, 5'h07, "R6");
    check("R6", "irq after clear", {14'd0, irq}, 16'h0000);
    // R5 clear on the same edge as a new rising transition on bit 0
    step(16'h0000, 0, 5'h07, 0, "R5"); idle(3, 5'h07, "R5");
    step(16'h0001, 0, 5'h07, 0, "R5"); step(pins, 0, 5'h07, 0, "R5");
    step(pins, 1, 5'h07, 8'h01, "R5"); step(pins, 0, 5'h07, 0, "R5");
    check("R5", "edge wins", {8'd0, rdata}, 16'h0001);
    step(pins, 1, 5'h07, 8'hFF, "R5");
    // R7 group 1 is separate
    step(pins, 1, 5'h15, 8'h80, "R7");
    step(16'h8001, 0, 5'h17, 0, "R7"); idle(3, 5'h17, "R7");
    check("R7", "group1 flag", {8'd0, rdata}, 16'h0080);
    check("R7", "irq lines", {14'd0, irq}, 16'h0002);
    step(pins, 0, 5'h07, 0, "R7");
    step(pins, 1, 5'h17, 8'h80, "R7");
    // R8 level register latency
    step(16'h805A, 0, 5'h00, 0, "R8"); step(pins, 0, 5'h00, 0, "R8");
    step(pins, 0, 5'h00, 0, "R8");
    check("R8", "level", {8'd0, rdata}, 16'h005A);
    step(pins, 0, 5'h10, 0, "R8");
    // random traffic, R1 R2 R4 R5 R6 R7 by model
    void'($urandom(32'd20240607));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] np = pins ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      int r = int'($urandom % 10);
      logic [4:0] a = {1'($urandom), 4'h0};
      if (r < 3) begin
        case ($urandom % 3)
          0: a[3:0] = 4'h5;
          1: a[3:0] = 4'h6;
          default: a[3:0] = 4'h7;
        endcase
        step(np, 1, a, 8'($urandom), "RND R4 R6");
      end else begin
        a[3:0] = 4'($urandom % 9);
        step(np, 0, a, 0, "RND R1 R2 R7");
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule